// File: doc/BRIEF.md
# Register Window Access Protection Unit

This unit sits in front of a small window of 32-bit configuration registers and filters every bus access to them. Each register in the window has one protection bit in a bitmap. When the bit is set, any initiator may reach the register. When it is clear, only an initiator that is both secure and privileged may reach it. Each access is also checked for a mapped address and for the register's read-only or write-only attribute.

An access that fails a check does not touch the target. A blocked read returns zero and a blocked write is dropped. Either way the access completes one cycle later, like any other. The failure is recorded as a class bit in a sticky cause register. The byte address of the first failing access is held in an error-address register until software has cleared every cause bit. Software clears a bit by writing a one to it.

The default window is 256 bytes and holds 64 register slots:
- Sixteen data registers sit at offsets 0x00 to 0x3C.
- Two bitmap words sit at 0x80 and 0x84.
- The cause register sits at 0x90.
- The error-address register sits at 0x94.

Top module: `reg_guard`

## Requirements
- R1: After reset, `ack_o` is low and every data register, bitmap bit, cause bit and error-address bit is zero.
- R2: Every cycle with `req_i` high produces `ack_o` high in the next cycle, with `rdata_o` valid in that same cycle. A cycle without a request produces no acknowledge. The unit never stalls.
- R3: The map is as follows. Byte offset o addresses slot o>>2. Data register k sits at 4k for k < 16. Bitmap word j sits at 0x80+4j and holds the bits of slots 32j..32j+31, with bit n of the word belonging to slot 32j+n. The cause register sits at 0x90 and the error address at 0x94. Any other offset, and any offset whose two low bits are not zero, is unmapped.
- R4: A data register whose bitmap bit is 1 accepts any initiator. A data register whose bit is 0 accepts only an initiator with `priv_i`=1 and `secure_i`=1. The bitmap words, the cause register and the error address always require a secure privileged initiator, whatever their bitmap bits hold.
- R5: A refused read of a mapped register sets cause bit 0 when unprivileged and bit 1 when non-secure; both may be set together. A read of an unmapped offset sets bit 2.
- R6: A refused write with `ext_i`=0 sets bit 3 when unprivileged and bit 4 when non-secure. A write with `ext_i`=0 to an unmapped offset sets bit 5.
- R7: A refused write with `ext_i`=1 sets bit 16. A write with `ext_i`=1 to an unmapped offset sets bit 17.
- R8: Data registers 12 and 13 are read-only and read 0x5A00_0000 plus their index. Data registers 14 and 15 are write-only. Reading a write-only register sets bit 24. Writing a read-only register, or writing the error-address register, sets bit 25.
- R9: An access that sets any cause bit is blocked. A blocked read returns zero. A blocked write changes no register.
- R10: Writing the cause register clears exactly the bits that are one in the written value. Bits other than 0-5, 16, 17, 24 and 25 always read zero.
- R11: The error address captures the byte address of a failing access only while the cause register is zero. It keeps that value while any cause bit remains set.
- R12: Each failing access reports one class only. The unmapped check comes first, then the protection check, then the read-only or write-only check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| priv_i | input | 1 | Initiator is privileged |
| secure_i | input | 1 | Initiator is secure |
| ext_i | input | 1 | Write arrives from the external interface |
| ack_o | output | 1 | Access completed, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with `ack_o`; zero for writes and blocked reads |

## Verification
An access is driven on a falling edge and is taken at the next rising edge. Its acknowledge, its read data, its cause bits and any register it writes all appear after that one edge. The bench therefore samples `ack_o` and `rdata_o` on the following falling edge. Side effects in the cause and error-address registers are observed through later secure privileged reads, and each of those reads carries the same one-cycle latency. A bench model predicts every response, and random access streams with a fixed seed run alongside directed cases for priority, write-one-to-clear and first-address capture.

// File: rtl/reg_guard_pkg.sv
package reg_guard_pkg;
  localparam int unsigned RD_PRIV   = 0;
  localparam int unsigned RD_SEC    = 1;
  localparam int unsigned RD_UNMAP  = 2;
  localparam int unsigned WR_PRIV   = 3;
  localparam int unsigned WR_SEC    = 4;
  localparam int unsigned WR_UNMAP  = 5;
  localparam int unsigned EXT_SEC   = 16;
  localparam int unsigned EXT_UNMAP = 17;
  localparam int unsigned RD_WO     = 24;
  localparam int unsigned WR_RO     = 25;
  localparam logic [31:0] CAUSE_MASK = 32'h0303_003F;
endpackage

// File: rtl/reg_guard_decode.sv
module reg_guard_decode
  import reg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_DATA = 16,
  parameter int unsigned N_PW   = 2,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h80,
  parameter logic [ADDR_W-1:0] CAUSE_OFFS = 8'h90,
  parameter logic [ADDR_W-1:0] EADDR_OFFS = 8'h94,
  parameter logic [N_DATA-1:0] RO_MASK = 16'h3000,
  parameter logic [N_DATA-1:0] WO_MASK = 16'hC000,
  localparam int unsigned REG_IW  = ADDR_W - 2,
  localparam int unsigned DATA_IW = (N_DATA > 1) ? $clog2(N_DATA) : 1,
  localparam int unsigned PW_W    = (N_PW > 1) ? $clog2(N_PW) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic                priv_i,
  input  logic                secure_i,
  input  logic                ext_i,
  input  logic [N_PW*32-1:0]  prot_i,
  output logic                hit_data_o,
  output logic                hit_pw_o,
  output logic                hit_cause_o,
  output logic                hit_eaddr_o,
  output logic                ro_o,
  output logic [DATA_IW-1:0]  didx_o,
  output logic [PW_W-1:0]     pw_sel_o,
  output logic [31:0]         viol_o
);
  logic [REG_IW-1:0] idx;
  logic [ADDR_W-1:0] pw_word;
  logic aligned, mapped, open, wo, sec_ok;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign pw_word = (addr_i - PROT_BASE) >> 2;
  assign didx_o  = idx[DATA_IW-1:0];

  assign hit_data_o  = aligned && (idx < REG_IW'(N_DATA));
  assign hit_pw_o    = aligned && (addr_i >= PROT_BASE) && (pw_word < ADDR_W'(N_PW));
  assign hit_cause_o = (addr_i == CAUSE_OFFS);
  assign hit_eaddr_o = (addr_i == EADDR_OFFS);
  assign pw_sel_o    = pw_word[PW_W-1:0];
  assign mapped      = hit_data_o || hit_pw_o || hit_cause_o || hit_eaddr_o;

  assign ro     = 1'b0;
  assign ro_o   = hit_data_o && RO_MASK[didx_o];
  assign wo     = hit_data_o && WO_MASK[didx_o];
  // control registers ignore their bitmap bits
  assign open   = hit_data_o && prot_i[idx];
  assign sec_ok = open || (priv_i && secure_i);

  logic ro;

  always_comb begin
    viol_o = '0;
    if (!mapped) begin
      if (!we_i)      viol_o[RD_UNMAP]  = 1'b1;
      else if (ext_i) viol_o[EXT_UNMAP] = 1'b1;
      else            viol_o[WR_UNMAP]  = 1'b1;
    end else if (!sec_ok) begin
      if (!we_i) begin
        viol_o[RD_PRIV] = !priv_i;
        viol_o[RD_SEC]  = !secure_i;
      end else if (ext_i) begin
        viol_o[EXT_SEC] = 1'b1;
      end else begin
        viol_o[WR_PRIV] = !priv_i;
        viol_o[WR_SEC]  = !secure_i;
      end
    end else if (!we_i && wo) begin
      viol_o[RD_WO] = 1'b1;
    end else if (we_i && (ro_o || hit_eaddr_o)) begin
      viol_o[WR_RO] = 1'b1;
    end
  end
endmodule

// File: rtl/reg_guard_store.sv
module reg_guard_store #(
  parameter int unsigned N_DATA = 16,
  parameter int unsigned N_PW   = 2,
  localparam int unsigned DATA_IW = (N_DATA > 1) ? $clog2(N_DATA) : 1,
  localparam int unsigned PW_W    = (N_PW > 1) ? $clog2(N_PW) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_data_en_i,
  input  logic [DATA_IW-1:0]       wr_idx_i,
  input  logic                     wr_pw_en_i,
  input  logic [PW_W-1:0]          pw_sel_i,
  input  logic [31:0]              wdata_i,
  output logic [N_DATA-1:0][31:0]  data_o,
  output logic [N_PW*32-1:0]       prot_o
);
  for (genvar g = 0; g < N_DATA; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_o[g] <= '0;
      else if (wr_data_en_i && (wr_idx_i == DATA_IW'(g))) data_o[g] <= wdata_i;
    end
  end

  for (genvar w = 0; w < N_PW; w++) begin : g_pw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prot_o[w*32 +: 32] <= '0;
      else if (wr_pw_en_i && (pw_sel_i == PW_W'(w))) prot_o[w*32 +: 32] <= wdata_i;
    end
  end

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_en_i |=> $stable(data_o));
  p_prot_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pw_en_i |=> $stable(prot_o));
endmodule

// File: rtl/reg_guard_errlog.sv
module reg_guard_errlog
  import reg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       set_vec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_en_i,
  input  logic [31:0]       clr_val_i,
  output logic [31:0]       cause_o,
  output logic [ADDR_W-1:0] eaddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      eaddr_o <= '0;
    end else if (set_vec_i != '0) begin
      if (cause_o == '0) eaddr_o <= addr_i;
      cause_o <= cause_o | (set_vec_i & CAUSE_MASK);
    end else if (clr_en_i) begin
      cause_o <= cause_o & ~clr_val_i;
    end
  end

  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_vec_i == '0) |=> cause_o == ($past(cause_o) & ~$past(clr_val_i)));
  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o & ~CAUSE_MASK) == '0);
  p_eaddr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != '0) |=> $stable(eaddr_o));
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec_i != '0) |=> (cause_o != '0));
endmodule

// File: rtl/reg_guard.sv
module reg_guard #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_DATA = 16,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h80,
  parameter logic [ADDR_W-1:0] CAUSE_OFFS = 8'h90,
  parameter logic [ADDR_W-1:0] EADDR_OFFS = 8'h94,
  parameter logic [N_DATA-1:0] RO_MASK = 16'h3000,
  parameter logic [N_DATA-1:0] WO_MASK = 16'hC000,
  parameter logic [31:0] RO_BASE = 32'h5A00_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              priv_i,
  input  logic              secure_i,
  input  logic              ext_i,
  output logic              ack_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned N_SLOTS = (2 ** ADDR_W) / 4;
  localparam int unsigned N_PW    = (N_SLOTS + 31) / 32;
  localparam int unsigned DATA_IW = (N_DATA > 1) ? $clog2(N_DATA) : 1;
  localparam int unsigned PW_W    = (N_PW > 1) ? $clog2(N_PW) : 1;

  logic hit_data, hit_pw, hit_cause, hit_eaddr, ro, blocked;
  logic [DATA_IW-1:0] didx;
  logic [PW_W-1:0] pw_sel;
  logic [31:0] viol, viol_act, cause, rd_val;
  logic [ADDR_W-1:0] eaddr;
  logic [N_DATA-1:0][31:0] data;
  logic [N_PW*32-1:0] prot;
  logic wr_data_en, wr_pw_en, clr_en;

  reg_guard_decode #(
    .ADDR_W(ADDR_W), .N_DATA(N_DATA), .N_PW(N_PW), .PROT_BASE(PROT_BASE),
    .CAUSE_OFFS(CAUSE_OFFS), .EADDR_OFFS(EADDR_OFFS),
    .RO_MASK(RO_MASK), .WO_MASK(WO_MASK)
  ) u_dec (
    .addr_i(addr_i), .we_i(we_i), .priv_i(priv_i), .secure_i(secure_i),
    .ext_i(ext_i), .prot_i(prot), .hit_data_o(hit_data), .hit_pw_o(hit_pw),
    .hit_cause_o(hit_cause), .hit_eaddr_o(hit_eaddr), .ro_o(ro),
    .didx_o(didx), .pw_sel_o(pw_sel), .viol_o(viol)
  );

  assign viol_act   = req_i ? viol : '0;
  assign blocked    = |viol_act;
  assign wr_data_en = req_i && we_i && hit_data && !blocked;
  assign wr_pw_en   = req_i && we_i && hit_pw && !blocked;
  assign clr_en     = req_i && we_i && hit_cause && !blocked;

  reg_guard_store #(.N_DATA(N_DATA), .N_PW(N_PW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_en_i(wr_data_en), .wr_idx_i(didx),
    .wr_pw_en_i(wr_pw_en), .pw_sel_i(pw_sel), .wdata_i(wdata_i),
    .data_o(data), .prot_o(prot)
  );

  reg_guard_errlog #(.ADDR_W(ADDR_W)) u_log (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_vec_i(viol_act), .addr_i(addr_i),
    .clr_en_i(clr_en), .clr_val_i(wdata_i), .cause_o(cause), .eaddr_o(eaddr)
  );

  always_comb begin
    rd_val = '0;
    if (hit_data)       rd_val = ro ? (RO_BASE + {{(32-DATA_IW){1'b0}}, didx}) : data[didx];
    else if (hit_pw)    rd_val = prot[pw_sel*32 +: 32];
    else if (hit_cause) rd_val = cause;
    else if (hit_eaddr) rd_val = {{(32-ADDR_W){1'b0}}, eaddr};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= (req_i && !we_i && !blocked) ? rd_val : '0;
    end
  end

  p_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  p_no_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  p_blocked_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && blocked) |=> (rdata_o == '0));
  p_prot_guard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && secure_i && priv_i) |=> $stable(prot));
endmodule

// File: tb/reg_guard_test.sv
module reg_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, priv = 1'b0, sec = 1'b0, ext = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack;
  logic [31:0] rdata;
  int total = 0, bad = 0;

  logic [31:0] m_data [16];
  logic [63:0] m_prot;
  logic [31:0] m_cause;
  logic [7:0]  m_eaddr;

  always #10 clk = ~clk;

  reg_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .priv_i(priv), .secure_i(sec), .ext_i(ext),
    .ack_o(ack), .rdata_o(rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic pv, input logic sc, input logic ex,
                       output logic [31:0] exp);
    logic [31:0] v;
    logic aligned, is_data, is_pw, is_c, is_e, open;
    int i;
    v = '0; exp = '0;
    aligned = (a[1:0] == 2'b00);
    i = int'(a >> 2);
    is_data = aligned && (a < 8'h40);
    is_pw   = (a == 8'h80) || (a == 8'h84);
    is_c    = (a == 8'h90);
    is_e    = (a == 8'h94);
    open    = is_data && m_prot[i];
    if (!(is_data || is_pw || is_c || is_e)) begin
      if (!w) v[2] = 1'b1; else if (ex) v[17] = 1'b1; else v[5] = 1'b1;
    end else if (!(open || (pv && sc))) begin
      if (!w) begin v[0] = !pv; v[1] = !sc; end
      else if (ex) v[16] = 1'b1;
      else begin v[3] = !pv; v[4] = !sc; end
    end else if (!w && is_data && (i == 14 || i == 15)) v[24] = 1'b1;
    else if (w && ((is_data && (i == 12 || i == 13)) || is_e)) v[25] = 1'b1;
    if (v != 0) begin
      if (m_cause == 0) m_eaddr = a;
      m_cause = m_cause | v;
    end else if (!w) begin
      if (is_data) exp = (i == 12 || i == 13) ? 32'h5A00_0000 + i : m_data[i];
      else if (is_pw) exp = (a == 8'h80) ? m_prot[31:0] : m_prot[63:32];
      else if (is_c) exp = m_cause;
      else exp = {24'h0, m_eaddr};
    end else begin
      if (is_data) m_data[i] = d;
      else if (a == 8'h80) m_prot[31:0] = d;
      else if (a == 8'h84) m_prot[63:32] = d;
      else if (is_c) m_cause = m_cause & ~d;
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic pv, input logic sc, input logic ex, input string tag);
    logic [31:0] exp;
    model(w, a, d, pv, sc, ex, exp);
    req = 1'b1; we = w; addr = a; wdata = d; priv = pv; sec = sc; ext = ex;
    @(negedge clk);
    chk({31'h0, ack}, 32'h1, "R2 ack one cycle later");
    chk(rdata, w ? 32'h0 : exp, tag);
    req = 1'b0; we = 1'b0; ext = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    acc(1'b0, a, 32'h0, 1'b1, 1'b1, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 1'b1, 1'b1, 1'b0, "R2 write");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    for (int k = 0; k < 16; k++) m_data[k] = '0;
    m_prot = '0; m_cause = '0; m_eaddr = '0;
    r = $urandom(32'd7719);
    repeat (3) @(negedge clk);
    chk({31'h0, ack}, 32'h0, "R1 ack low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({31'h0, ack}, 32'h0, "R2 no ack without request");
    rd(8'h90, "R1 cause zero");
    rd(8'h80, "R1 bitmap word0 zero");
    rd(8'h84, "R1 bitmap word1 zero");
    rd(8'h94, "R1 eaddr zero");
    rd(8'h08, "R1 data zero");
    chk(rdata, 32'h0, "R1 data zero literal");

    wr(8'h00, 32'h1234_5678);
    rd(8'h00, "R3 data readback");
    chk(rdata, 32'h1234_5678, "R3 data literal");

    acc(1'b0, 8'h00, 0, 1'b1, 1'b0, 1'b0, "R9 non-secure read blocked");
    rd(8'h90, "R5 non-secure read bit1");
    chk(rdata, 32'h2, "R5 cause literal");
    acc(1'b1, 8'h04, 32'hDEAD, 1'b0, 1'b0, 1'b0, "R6 write blocked");
    rd(8'h90, "R6 unpriv non-secure write bits 3,4");
    chk(rdata, 32'h1A, "R6 cause literal");
    rd(8'h94, "R11 first address kept");
    chk(rdata, 32'h0, "R11 eaddr literal");
    rd(8'h04, "R9 blocked write discarded");
    wr(8'h90, 32'h2);
    rd(8'h90, "R10 partial clear");
    chk(rdata, 32'h18, "R10 partial literal");
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, "R10 full clear");

    wr(8'h80, 32'h1);
    acc(1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b0, "R4 open register readable");
    chk(rdata, 32'h1234_5678, "R4 open literal");
    rd(8'h90, "R4 no violation on open reg");

    acc(1'b1, 8'h04, 32'h55, 1'b1, 1'b0, 1'b1, "R7 ext write");
    acc(1'b1, 8'h44, 32'h55, 1'b1, 1'b1, 1'b1, "R7 ext unmapped write");
    rd(8'h90, "R7 bits 16 and 17");
    chk(rdata, 32'h0003_0000, "R7 literal");
    rd(8'h94, "R11 address of first ext violation");
    chk(rdata, 32'h04, "R11 literal");
    wr(8'h90, 32'hFFFF_FFFF);

    rd(8'h40, "R5 unmapped read");
    rd(8'h01, "R3 misaligned read unmapped");
    acc(1'b1, 8'h98, 32'h1, 1'b1, 1'b1, 1'b0, "R6 unmapped write");
    rd(8'h90, "R5 R6 unmapped bits");
    chk(rdata, 32'h24, "R6 unmapped literal");
    rd(8'h94, "R11 eaddr unmapped");
    chk(rdata, 32'h40, "R11 unmapped literal");
    wr(8'h90, 32'hFFFF_FFFF);

    rd(8'h30, "R8 read-only value");
    chk(rdata, 32'h5A00_000C, "R8 ro literal");
    wr(8'h30, 32'h1);
    wr(8'h38, 32'hABCD);
    rd(8'h38, "R8 write-only read blocked");
    wr(8'h94, 32'h1);
    rd(8'h90, "R8 bits 24 and 25");
    chk(rdata, 32'h0300_0000, "R8 literal");
    wr(8'h90, 32'hFFFF_FFFF);

    wr(8'h84, 32'h0000_0010);
    rd(8'h84, "R3 bitmap word1 readback");
    acc(1'b0, 8'h90, 0, 1'b1, 1'b0, 1'b0, "R4 control reg restricted despite bit");
    rd(8'h90, "R4 control violation logged");
    chk(rdata, 32'h2, "R4 control literal");
    wr(8'h90, 32'hFFFF_FFFF);

    acc(1'b0, 8'h48, 0, 1'b0, 1'b0, 1'b0, "R12 unmapped before protection");
    acc(1'b1, 8'h34, 1, 1'b0, 1'b1, 1'b0, "R12 protection before read-only");
    rd(8'h90, "R12 single class per access");
    chk(rdata, 32'h0C, "R12 literal");
    wr(8'h90, 32'hFFFF_FFFF);

    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      logic w, pv, sc, ex;
      logic [31:0] d;
      int sel;
      sel = int'($urandom % 8);
      case (sel)
        0, 1, 2: a = 8'(($urandom % 16) * 4);
        3: a = ($urandom % 2 == 0) ? 8'h80 : 8'h84;
        4: a = 8'h90;
        5: a = 8'h94;
        6: a = 8'h40 + 8'(($urandom % 16) * 4);
        default: a = 8'($urandom);
      endcase
      w  = $urandom % 2 == 0;
      pv = $urandom % 4 != 0;
      sc = $urandom % 4 != 0;
      ex = w && ($urandom % 4 == 0);
      d  = $urandom;
      acc(w, a, d, pv, sc, ex, "R9 random access read data");
      if (n % 10 == 9) begin
        rd(8'h90, "R10 random cause check");
        rd(8'h94, "R11 random eaddr check");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule